// File: doc/BRIEF.md
# Multi-Cycle Accumulator Machine Sequencer

This block executes the memory-reference instructions of a 12-bit accumulator machine, one at a time, over several clock cycles. It holds the program counter (a 3-bit field on top of a 12-bit in-field address), the accumulator, the link bit, a data-field and instruction-field buffer, a two-bit interrupt-enable register and a halt flag. All instruction and operand traffic goes through one single-port synchronous memory with a one-cycle read latency.

Each instruction is fetched and decoded. Then only the steps it needs are taken, in a fixed order: pointer read, pointer increment write-back, operand load, execute with register write-back, operand store and PC update. A step that is not needed costs no cycle. A one-cycle retirement pulse presents the updated PC, accumulator and link. Encodings that are not memory-reference instructions stop the machine.

Top module: `acm_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pc_out` equals the parameter RESET_PC (octal 0200 by default), `acc_out` and `link_out` are 0, `int_en`, `halted` and `instr_done` are 0.
- R2: Every access takes one cycle. A read returns its data on the next cycle. Read and write strobes are never high together. `instr_done` is high for exactly one cycle per retired instruction, with `pc_out`/`acc_out`/`link_out` already holding their new values. Without a jump or skip, the PC advances by one: the low 12 bits wrap and the field stays the same.
- R3: The instruction word is split as follows. Bits 11:9 are the opcode. Bit 8 selects indirect addressing. Bit 7 selects the current page (the instruction's own PC bits 11:7); when bit 7 is 0, page zero is used. Bits 6:0 are the in-page offset. A direct operand address or a pointer location lies in the PC's field. An indirect final address lies in the data field.
- R4: Autoincrement applies to an indirect, non-jump instruction whose pointer sits at page-zero offsets 010 to 017. The block writes (pointer + 1) mod 4096 back to the pointer and uses the incremented value as the operand address. Jumps through such a pointer leave it unchanged.
- R5: Opcode 0 (AND) replaces the accumulator with its bitwise AND with the operand.
- R6: Opcode 1 (TAD) forms link·4096 + accumulator + operand. The accumulator takes the low 12 bits of the sum and the link takes bit 12.
- R7: Opcode 2 (ISZ) stores (operand + 1) mod 4096. When that stored value is nonzero, the next PC is advanced by one more within the field.
- R8: Opcode 3 (DCA) stores the accumulator at the operand address and then clears the accumulator.
- R9: Opcode 4 (JMS) stores the 12-bit return address (instruction address + 1) at {instruction-field buffer, A}, where A is the operand address. It then continues at {instruction-field buffer, (A + 1) mod 4096}.
- R10: Opcode 5 (JMP) loads the PC with {instruction-field buffer, A}.
- R11: The interrupt-enable register holds {delay, enable}. At the start of every instruction, both bits take the old delay bit. A pulse on `ie_set` sets the delay bit. A request made during instruction k shows `int_en` = 0 at k's retirement and 1 from the retirement of k+1 onward.
- R12: Opcodes 6 and 7 set `halted`. After that no instruction retires, the PC keeps the address of the stopping word, and neither memory strobe is raised again.
- R13: A cycle with `fld_wr` high loads the data field from `fld_wdata[5:3]` and the instruction-field buffer from `fld_wdata[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_wr | input | 1 | Load strobe for the field registers |
| fld_wdata | input | 6 | {data field, instruction-field buffer} |
| ie_set | input | 1 | Sets the interrupt-enable delay bit |
| mem_rdata | input | 12 | Read data, valid one cycle after a read strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 15 | Memory address {field, in-field address} |
| mem_wdata | output | 12 | Memory write data |
| instr_done | output | 1 | One-cycle retirement pulse |
| pc_out | output | 15 | Program counter |
| acc_out | output | 12 | Accumulator |
| link_out | output | 1 | Link bit |
| int_en | output | 1 | Interrupt-enable bit |
| halted | output | 1 | Machine stopped |

## Verification
The program drives TAD through a carry out and then through a link-in carry. A design that drops the link term or keeps bit 13 would show the wrong accumulator. The program also increments an autoincrement pointer and jumps through a pointer in the same page-zero window. A design that uses the stale pointer value, or that increments on jumps, leaves a wrong pointer or loads the wrong operand. Further targets are ISZ with both a zero and a nonzero result, JMS/JMP into a field different from the current one, and current-page addressing. A skipped halt word and a late interrupt enable would expose a wrong skip sense or a missing delay stage.

// File: rtl/acm_pkg.sv
package acm_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_IND, S_PTR, S_AINC, S_LOAD, S_EXEC, S_STORE, S_HALT
  } st_e;

  typedef struct packed {
    op_e  op;
    logic ind;    // indirect through a pointer
    logic ainc;   // pointer increment write-back
    logic load;   // operand read
    logic store;  // operand write
    logic jump;   // target field from instruction-field buffer
    logic stop;   // not a memory-reference opcode
  } dec_t;
endpackage

// File: rtl/acm_decode.sv
module acm_decode
  import acm_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0]    word,
  input  logic [4:0]       page,   // instruction's own page bits
  output dec_t             dec,
  output logic [DW-1:0]    ea
);
  localparam int OFFW = DW - 5;

  logic in_ainc_win;

  always_comb begin
    dec.op    = op_e'(word[DW-1 -: 3]);
    dec.stop  = (dec.op == OP_IOT) || (dec.op == OP_OPR);
    dec.jump  = (dec.op == OP_JMS) || (dec.op == OP_JMP);
    dec.load  = (dec.op == OP_AND) || (dec.op == OP_TAD) || (dec.op == OP_ISZ);
    dec.store = (dec.op == OP_ISZ) || (dec.op == OP_DCA) || (dec.op == OP_JMS);
    dec.ind   = word[DW-4] && !dec.stop;
    in_ainc_win = !word[OFFW] && (word[OFFW-1:3] == (OFFW-3)'(1));
    dec.ainc  = dec.ind && !dec.jump && in_ainc_win;
    ea = word[OFFW] ? {page, word[OFFW-1:0]}
                    : {{(DW-OFFW){1'b0}}, word[OFFW-1:0]};
  end
endmodule

// File: rtl/acm_exec.sv
module acm_exec
  import acm_pkg::*;
#(
  parameter int DW = 12,
  parameter int FW = 3
) (
  input  op_e              op,
  input  logic [DW-1:0]    acc,
  input  logic             link,
  input  logic [DW-1:0]    data,
  input  logic [DW-1:0]    ea,
  input  logic [FW+DW-1:0] pc,
  input  logic [FW-1:0]    ifb,
  output logic [DW-1:0]    acc_n,
  output logic             link_n,
  output logic [DW-1:0]    st_data,
  output logic [FW+DW-1:0] npc
);
  localparam int AW = FW + DW;

  logic [DW:0]   sum;
  logic [DW-1:0] inc, lo1, lo2;

  always_comb begin
    lo1 = pc[DW-1:0] + 1'b1;
    lo2 = pc[DW-1:0] + 2'd2;
    inc = data + 1'b1;
    sum = {link, {DW{1'b0}}} + {1'b0, acc} + {1'b0, data};
    acc_n   = acc;
    link_n  = link;
    st_data = data;
    npc     = {pc[AW-1:DW], lo1};
    case (op)
      OP_AND: acc_n = acc & data;
      OP_TAD: begin
        acc_n  = sum[DW-1:0];
        link_n = sum[DW];
      end
      OP_ISZ: begin
        st_data = inc;
        if (inc != '0) npc = {pc[AW-1:DW], lo2};
      end
      OP_DCA: begin
        st_data = acc;
        acc_n   = '0;
      end
      OP_JMS: begin
        st_data = lo1;
        npc     = {ifb, ea + 1'b1};
      end
      OP_JMP: npc = {ifb, ea};
      default: ;
    endcase
  end
endmodule

// File: rtl/acm_seq.sv
module acm_seq
  import acm_pkg::*;
#(
  parameter int DW = 12,
  parameter int FW = 3,
  parameter int unsigned RESET_PC = 'o200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fld_wr,
  input  logic [2*FW-1:0]      fld_wdata,
  input  logic                 ie_set,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [FW+DW-1:0]     mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 instr_done,
  output logic [FW+DW-1:0]     pc_out,
  output logic [DW-1:0]        acc_out,
  output logic                 link_out,
  output logic                 int_en,
  output logic                 halted
);
  localparam int AW   = FW + DW;
  localparam int OFFW = DW - 5;

  st_e           st;
  logic [AW-1:0] pc, op_addr, ptr_loc, npc_q;
  logic [DW-1:0] acc, ir, st_data_q;
  logic          link, halt_q, done_q;
  logic [FW-1:0] df, ifb;
  logic [1:0]    ie_q;

  // decode: live memory word during DEC, held word afterwards
  logic [DW-1:0] dword, ea, ptr_next;
  dec_t          dec;
  assign dword = (st == S_DEC) ? mem_rdata : ir;

  acm_decode #(.DW(DW)) u_dec (
    .word(dword), .page(pc[DW-1:OFFW]), .dec(dec), .ea(ea)
  );

  logic [DW-1:0] acc_n, st_data;
  logic          link_n;
  logic [AW-1:0] npc;

  acm_exec #(.DW(DW), .FW(FW)) u_exe (
    .op(dec.op), .acc(acc), .link(link), .data(mem_rdata),
    .ea(op_addr[DW-1:0]), .pc(pc), .ifb(ifb),
    .acc_n(acc_n), .link_n(link_n), .st_data(st_data), .npc(npc)
  );

  assign ptr_next = dec.ainc ? mem_rdata + 1'b1 : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_FETCH;
      pc        <= AW'(RESET_PC);
      acc       <= '0;
      link      <= 1'b0;
      df        <= '0;
      ifb       <= '0;
      ie_q      <= '0;
      halt_q    <= 1'b0;
      done_q    <= 1'b0;
      ir        <= '0;
      op_addr   <= '0;
      ptr_loc   <= '0;
      npc_q     <= '0;
      st_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (fld_wr) {df, ifb} <= fld_wdata;
      if (st == S_FETCH) ie_q <= {ie_q[1] | ie_set, ie_q[1]};
      else if (ie_set)   ie_q[1] <= 1'b1;
      case (st)
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          ir      <= mem_rdata;
          op_addr <= {pc[AW-1:DW], ea};
          ptr_loc <= {pc[AW-1:DW], ea};
          if (dec.stop) begin
            halt_q <= 1'b1;
            st     <= S_HALT;
          end else if (dec.ind) st <= S_IND;
          else                  st <= dec.load ? S_LOAD : S_EXEC;
        end
        S_IND: st <= S_PTR;
        S_PTR: begin
          op_addr <= {df, ptr_next};
          if (dec.ainc) st <= S_AINC;
          else          st <= dec.load ? S_LOAD : S_EXEC;
        end
        S_AINC: st <= dec.load ? S_LOAD : S_EXEC;
        S_LOAD: st <= S_EXEC;
        S_EXEC: begin
          acc       <= acc_n;
          link      <= link_n;
          st_data_q <= st_data;
          if (dec.store) begin
            npc_q <= npc;
            st    <= S_STORE;
          end else begin
            pc     <= npc;
            done_q <= 1'b1;
            st     <= S_FETCH;
          end
        end
        S_STORE: begin
          pc     <= npc_q;
          done_q <= 1'b1;
          st     <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  always_comb begin
    mem_rd    = (st == S_FETCH) || (st == S_IND) || (st == S_LOAD);
    mem_wr    = (st == S_AINC) || (st == S_STORE);
    mem_wdata = (st == S_AINC) ? op_addr[DW-1:0] : st_data_q;
    case (st)
      S_IND, S_AINC: mem_addr = ptr_loc;
      S_LOAD:        mem_addr = op_addr;
      S_STORE:       mem_addr = dec.jump ? {ifb, op_addr[DW-1:0]} : op_addr;
      default:       mem_addr = pc;
    endcase
  end

  assign instr_done = done_q;
  assign pc_out     = pc;
  assign acc_out    = acc;
  assign link_out   = link;
  assign int_en     = ie_q[0];
  assign halted     = halt_q;

  assert_rdwr_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done);
  assert_ainc_order_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_AINC) |-> ($past(st) == S_PTR));
  assert_ie_delay_R11: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (ie_q[0] == $past(ie_q[1])));
  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr && !instr_done));
endmodule

// File: tb/sim_acm_seq.sv
`timescale 1ns/1ps
module sim_acm_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fld_wr = 1'b0;
  logic [5:0]  fld_wdata = '0;
  logic        ie_set = 1'b0;
  logic [11:0] mem_rdata = '0;
  logic        mem_rd, mem_wr, instr_done, link_out, int_en, halted;
  logic [14:0] mem_addr, pc_out;
  logic [11:0] mem_wdata, acc_out;

  int checks = 0;
  int errors = 0;
  int retired = 0;

  always #4 clk = ~clk;

  acm_seq u0 (
    .clk(clk), .rst(rst), .fld_wr(fld_wr), .fld_wdata(fld_wdata),
    .ie_set(ie_set), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .instr_done(instr_done),
    .pc_out(pc_out), .acc_out(acc_out), .link_out(link_out),
    .int_en(int_en), .halted(halted)
  );

  // memory model: one-cycle read latency
  logic [11:0] mem [int];
  function automatic logic [11:0] peek(int a);
    return mem.exists(a) ? mem[a] : 12'o0000;
  endfunction
  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= peek(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // scoreboard
  typedef struct {
    logic [14:0] pc;
    logic [11:0] acc;
    logic        link;
    logic        ie;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  task automatic push_exp(input int pc, input int acc, input bit link,
                          input bit ie, input string req);
    exp_t e;
    e.pc = 15'(pc); e.acc = 12'(acc); e.link = link; e.ie = ie; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    ie_set = 1'b0;
    if (!rst && instr_done) begin
      retired++;
      if (exp_q.size() == 0) begin
        chk(1'b0, $sformatf("R2 unexpected retirement pc=%o expected none", pc_out));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pc_out == e.pc && acc_out == e.acc && link_out == e.link,
            $sformatf("%s step %0d pc/acc/link=%o/%o/%b expected %o/%o/%b",
                      e.req, retired, pc_out, acc_out, link_out, e.pc, e.acc, e.link));
        chk(int_en == e.ie, $sformatf("R11 step %0d int_en=%b expected %b",
                                      retired, int_en, e.ie));
      end
      if (retired == 3) ie_set = 1'b1;  // request during the fourth instruction
    end
  end

  task automatic put(input int a, input int v);
    mem[a] = 12'(v);
  endtask

  initial begin
    int strobes;
    int dones;
    // page-zero data, field 0
    put('o00010, 'o0377); put('o00020, 'o7777); put('o00021, 'o0001);
    put('o00022, 'o0003); put('o00024, 'o7777); put('o00025, 'o0005);
    put('o00026, 'o0100); put('o00250, 'o0010);
    // data field 2
    put('o20400, 'o0005); put('o20100, 'o0007);
    // field 1 pointers
    put('o10263, 'o0300); put('o10012, 'o0350);
    // program, field 0
    put('o00200, 'o1020); put('o00201, 'o1021); put('o00202, 'o1021);
    put('o00203, 'o1410); put('o00204, 'o0022); put('o00205, 'o3023);
    put('o00206, 'o2024); put('o00207, 'o2025); put('o00210, 'o7000);
    put('o00211, 'o1426); put('o00212, 'o1250); put('o00213, 'o4260);
    // program, field 1
    put('o10261, 'o3270); put('o10262, 'o5663); put('o10300, 'o5305);
    for (int a = 'o10301; a <= 'o10304; a++) put(a, 'o7000);
    put('o10305, 'o4412); put('o10351, 'o1350); put('o10352, 'o6000);

    push_exp('o00201, 'o7777, 0, 0, "R6");   // plain add
    push_exp('o00202, 'o0000, 1, 0, "R6");   // carry out into link
    push_exp('o00203, 'o0001, 1, 0, "R6");   // link joins the sum
    push_exp('o00204, 'o0006, 1, 0, "R4");   // autoincremented pointer
    push_exp('o00205, 'o0002, 1, 1, "R5");
    push_exp('o00206, 'o0000, 1, 1, "R8");
    push_exp('o00207, 'o0000, 1, 1, "R7");   // zero result: no skip
    push_exp('o00211, 'o0000, 1, 1, "R7");   // nonzero result: skip
    push_exp('o00212, 'o0007, 1, 1, "R3");   // indirect into data field
    push_exp('o00213, 'o0017, 1, 1, "R3");   // current page
    push_exp('o10261, 'o0017, 1, 1, "R9");
    push_exp('o10262, 'o0000, 1, 1, "R13");
    push_exp('o10300, 'o0000, 1, 1, "R10");
    push_exp('o10305, 'o0000, 1, 1, "R10");
    push_exp('o10351, 'o0000, 1, 1, "R9");
    push_exp('o10352, 'o0306, 1, 1, "R2");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc_out == 15'o00200, $sformatf("R1 pc=%o expected 00200", pc_out));
    chk(acc_out == 0 && link_out == 0,
        $sformatf("R1 acc/link=%o/%b expected 0/0", acc_out, link_out));
    chk(!int_en && !halted && !instr_done,
        $sformatf("R1 int_en/halted/done=%b%b%b expected 000", int_en, halted, instr_done));
    rst = 1'b0;
    fld_wr = 1'b1;
    fld_wdata = 6'o21;   // data field 2, instruction field 1
    @(negedge clk);
    fld_wr = 1'b0;

    for (int c = 0; c < 2000 && !halted; c++) @(negedge clk);
    chk(halted == 1'b1, $sformatf("R12 halted=%b expected 1", halted));
    chk(exp_q.size() == 0, $sformatf("R2 pending retirements=%0d expected 0", exp_q.size()));
    chk(pc_out == 15'o10352, $sformatf("R12 pc=%o expected 10352", pc_out));

    strobes = 0;
    dones = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) strobes++;
      if (instr_done) dones++;
    end
    chk(strobes == 0 && dones == 0,
        $sformatf("R12 strobes/retirements after halt=%0d/%0d expected 0/0", strobes, dones));
    chk(pc_out == 15'o10352 && acc_out == 12'o0306,
        $sformatf("R12 pc/acc after halt=%o/%o expected 10352/0306", pc_out, acc_out));

    chk(peek('o00010) == 12'o0400, $sformatf("R4 pointer=%o expected 0400", peek('o00010)));
    chk(peek('o10012) == 12'o0350, $sformatf("R4 jump pointer=%o expected 0350", peek('o10012)));
    chk(peek('o00023) == 12'o0002, $sformatf("R8 stored=%o expected 0002", peek('o00023)));
    chk(peek('o10270) == 12'o0017, $sformatf("R8 stored=%o expected 0017", peek('o10270)));
    chk(peek('o00024) == 12'o0000, $sformatf("R7 counter=%o expected 0000", peek('o00024)));
    chk(peek('o00025) == 12'o0006, $sformatf("R7 counter=%o expected 0006", peek('o00025)));
    chk(peek('o10260) == 12'o0214, $sformatf("R9 return=%o expected 0214", peek('o10260)));
    chk(peek('o10350) == 12'o0306, $sformatf("R9 return=%o expected 0306", peek('o10350)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired expected halt");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule